// File: doc/BRIEF.md
# Self-Test Result Log

This block keeps the results of device self-tests in a circular log of fixed size and presents the whole log as one 512-byte sector. A producer hands over each result as a 24-byte descriptor. The descriptor arrives as a byte stream: the first beat carries a start flag and the final beat carries a last flag. The block accepts a stream only if it is exactly 24 beats long. It then stores the descriptor in the next slot of a 21-slot ring. When all 21 slots are full, the oldest slot is replaced.

A consumer reads the sector one byte at a time by giving an offset. Offsets 0 and 1 hold a revision word. Descriptor slot N begins at offset 2 + 24·N. Offset 508 holds a pointer to the most recently written slot, counted from 1, where 0 means the log is empty. Offset 511 holds a checksum byte, chosen so that the 512 bytes add up to zero modulo 256. Every other offset reads zero.

A synchronous clear input empties the log. Running the self-tests and carrying the sector over a host bus are handled elsewhere.

Top module: `stl_selftest_log`

## Requirements
- R1: After reset the pointer is 0, and every sector byte except offsets 0, 1 and 511 reads 00h.
- R2: Offsets 0 and 1 read the low and high byte of the revision word (default 0001h, so 01h then 00h).
- R3: A stream of exactly 24 valid beats (start on the first, last on the final) raises `desc_accepted` for one cycle, in the cycle after the final beat. Its bytes appear in arrival order at offsets 2 + 24·S + k, where S is 0 if the pointer was 21 and otherwise equals the pointer.
- R4: After an accepted descriptor the pointer becomes S + 1, so it takes values 1 through 21. Offset 508 reads the pointer value.
- R5: Once all 21 slots hold descriptors, the next accepted descriptor replaces slot 0 and sets the pointer to 1. The other slots keep their contents.
- R6: A stream of fewer than 24 beats raises `desc_rejected` for one cycle after its final beat. The pointer and the log contents stay unchanged.
- R7: A stream of more than 24 beats is rejected in the same way as in R6, with no change to the pointer or the contents.
- R8: Offset 511 makes the sum of all 512 sector bytes equal to 0 modulo 256.
- R9: A beat carrying start while a stream is open discards the partial stream. The count starts again from that beat.
- R10: Offsets 506, 507, 509 and 510 read 00h.
- R11: `rd_data` shows the byte at the offset that `rd_addr` held one clock edge earlier.
- R12: Cycles with `wr_valid` low are ignored, so gaps inside a stream are allowed. Valid beats with no open stream and no start flag are ignored and raise no pulse.
- R13: A clear sets the pointer to 0, sets every descriptor byte to 00h and drops any partial stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear; empties the log |
| wr_valid | input | 1 | Descriptor beat valid |
| wr_start | input | 1 | Beat is the first of a descriptor |
| wr_last | input | 1 | Beat is the final one of a descriptor |
| wr_data | input | 8 | Descriptor byte |
| desc_accepted | output | 1 | One-cycle pulse: descriptor stored |
| desc_rejected | output | 1 | One-cycle pulse: descriptor length wrong, dropped |
| rd_addr | input | 9 | Sector byte offset |
| rd_data | output | 8 | Sector byte, registered |
| log_ptr | output | 5 | Most recent slot, 1-based, 0 when empty |

## Verification
A table drives streams of 24 beats mixed with streams of 1, 5, 23 and 30 beats. This separates an exact-length check from one that only counts up to 24 or stops at it.

Further streams contain idle gaps or a restart part way through. These show whether the beat counter advances only on valid beats and resets on a start flag.

The log is then filled past 21 entries and read back in full after each phase, with the sum of all bytes checked against zero. This confirms the ring placement, that only the oldest slot is overwritten, and that the checksum follows the pointer and the contents after a wrap and after a clear.

// File: rtl/stl_pkg.sv
package stl_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BODY = 1'b1
  } rx_state_e;

  // slot that receives the next descriptor, given the 1-based pointer
  function automatic int unsigned slot_after(input int unsigned ptr,
                                             input int unsigned entries);
    return (ptr >= entries) ? 0 : ptr;
  endfunction

  // byte that brings the sum of all listed parts to zero modulo 256
  function automatic logic [7:0] zero_sum_byte(input logic [7:0] a,
                                               input logic [7:0] b,
                                               input logic [7:0] c,
                                               input logic [7:0] d);
    logic [7:0] s;
    s = a + b + c + d;
    return 8'(8'd0 - s);
  endfunction

endpackage

// File: rtl/stl_stream_rx.sv
module stl_stream_rx #(
  parameter int unsigned DESC_BYTES = 24,
  localparam int unsigned DESC_W = DESC_BYTES * 8,
  localparam int unsigned CNT_W  = $clog2(DESC_BYTES + 1),
  localparam int unsigned BYTE_W = $clog2(DESC_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic              in_last,
  input  logic [7:0]        in_data,
  output logic              commit,
  output logic              reject,
  output logic [DESC_W-1:0] desc
);
  import stl_pkg::*;

  rx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             ovr;
  logic [7:0]       stage [DESC_BYTES];

  logic full_now;
  logic length_ok;
  assign full_now  = (cnt == CNT_W'(DESC_BYTES));
  assign length_ok = !ovr && (cnt == CNT_W'(DESC_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      ovr    <= 1'b0;
      commit <= 1'b0;
      reject <= 1'b0;
    end else begin
      commit <= 1'b0;
      reject <= 1'b0;
      if (clr) begin
        st  <= RX_IDLE;
        cnt <= '0;
        ovr <= 1'b0;
      end else if (in_valid) begin
        if (in_start) begin
          cnt <= CNT_W'(1);
          ovr <= 1'b0;
          if (in_last) begin
            st <= RX_IDLE;
            if (DESC_BYTES == 1) commit <= 1'b1;
            else                 reject <= 1'b1;
          end else begin
            st <= RX_BODY;
          end
        end else if (st == RX_BODY) begin
          if (full_now) ovr <= 1'b1;
          else          cnt <= cnt + CNT_W'(1);
          if (in_last) begin
            st <= RX_IDLE;
            if (length_ok) commit <= 1'b1;
            else           reject <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && !clr) begin
      if (in_start)
        stage[0] <= in_data;
      else if (st == RX_BODY && !full_now)
        stage[BYTE_W'(cnt)] <= in_data;
    end
  end

  for (genvar g = 0; g < DESC_BYTES; g++) begin : g_pack
    assign desc[g*8 +: 8] = stage[g];
  end

endmodule

// File: rtl/stl_log_store.sv
module stl_log_store #(
  parameter int unsigned ENTRIES    = 21,
  parameter int unsigned DESC_BYTES = 24,
  localparam int unsigned DESC_W = DESC_BYTES * 8,
  localparam int unsigned PTR_W  = $clog2(ENTRIES + 1),
  localparam int unsigned SLOT_W = $clog2(ENTRIES),
  localparam int unsigned BYTE_W = $clog2(DESC_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              commit,
  input  logic [DESC_W-1:0] desc,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [7:0]        entry_byte,
  output logic [PTR_W-1:0]  log_ptr,
  output logic [7:0]        body_sum
);
  import stl_pkg::*;

  logic [DESC_W-1:0] mem  [ENTRIES];
  logic [7:0]        esum [ENTRIES];

  logic [SLOT_W-1:0] wr_slot;
  logic [7:0]        new_sum;
  logic [DESC_W-1:0] rd_entry;

  function automatic logic [7:0] desc_bytes_sum(input logic [DESC_W-1:0] d);
    logic [7:0] s;
    s = '0;
    for (int i = 0; i < DESC_BYTES; i++) s = s + d[i*8 +: 8];
    return s;
  endfunction

  assign wr_slot = SLOT_W'(slot_after(int'(log_ptr), ENTRIES));
  assign new_sum = desc_bytes_sum(desc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_ptr  <= '0;
      body_sum <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        mem[i]  <= '0;
        esum[i] <= '0;
      end
    end else if (clr) begin
      log_ptr  <= '0;
      body_sum <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        mem[i]  <= '0;
        esum[i] <= '0;
      end
    end else if (commit) begin
      mem[wr_slot]  <= desc;
      esum[wr_slot] <= new_sum;
      body_sum      <= body_sum - esum[wr_slot] + new_sum;
      log_ptr       <= PTR_W'(int'(wr_slot) + 1);
    end
  end

  assign rd_entry   = mem[rd_slot];
  assign entry_byte = rd_entry[int'(rd_byte)*8 +: 8];

endmodule

// File: rtl/stl_sector_map.sv
module stl_sector_map #(
  parameter int unsigned ENTRIES      = 21,
  parameter int unsigned DESC_BYTES   = 24,
  parameter int unsigned SECTOR_BYTES = 512,
  parameter logic [15:0] REVISION     = 16'h0001,
  localparam int unsigned ADDR_W   = $clog2(SECTOR_BYTES),
  localparam int unsigned PTR_W    = $clog2(ENTRIES + 1),
  localparam int unsigned SLOT_W   = $clog2(ENTRIES),
  localparam int unsigned BYTE_W   = $clog2(DESC_BYTES),
  localparam int          BODY_LO  = 2,
  localparam int          BODY_HI  = BODY_LO + ENTRIES * DESC_BYTES,
  localparam int          PTR_OFS  = SECTOR_BYTES - 4,
  localparam int          CSUM_OFS = SECTOR_BYTES - 1
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [PTR_W-1:0]  log_ptr,
  input  logic [7:0]        body_sum,
  input  logic [7:0]        entry_byte,
  output logic [SLOT_W-1:0] rd_slot,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [7:0]        sector_byte
);
  import stl_pkg::*;

  int   off;
  int   rel;
  logic in_body;
  logic [7:0] csum;

  assign off     = int'(rd_addr);
  assign rel     = off - BODY_LO;
  assign in_body = (off >= BODY_LO) && (off < BODY_HI);
  assign rd_slot = in_body ? SLOT_W'(rel / DESC_BYTES) : '0;
  assign rd_byte = in_body ? BYTE_W'(rel % DESC_BYTES) : '0;
  assign csum    = zero_sum_byte(REVISION[7:0], REVISION[15:8],
                                 8'(log_ptr), body_sum);

  always_comb begin
    if (off == 0)             sector_byte = REVISION[7:0];
    else if (off == 1)        sector_byte = REVISION[15:8];
    else if (in_body)         sector_byte = entry_byte;
    else if (off == PTR_OFS)  sector_byte = 8'(log_ptr);
    else if (off == CSUM_OFS) sector_byte = csum;
    else                      sector_byte = 8'h00;
  end

endmodule

// File: rtl/stl_selftest_log.sv
module stl_selftest_log #(
  parameter int unsigned ENTRIES      = 21,
  parameter int unsigned DESC_BYTES   = 24,
  parameter int unsigned SECTOR_BYTES = 512,
  parameter logic [15:0] REVISION     = 16'h0001,
  localparam int unsigned ADDR_W = $clog2(SECTOR_BYTES),
  localparam int unsigned PTR_W  = $clog2(ENTRIES + 1),
  localparam int unsigned SLOT_W = $clog2(ENTRIES),
  localparam int unsigned BYTE_W = $clog2(DESC_BYTES),
  localparam int unsigned DESC_W = DESC_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_valid,
  input  logic              wr_start,
  input  logic              wr_last,
  input  logic [7:0]        wr_data,
  output logic              desc_accepted,
  output logic              desc_rejected,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [PTR_W-1:0]  log_ptr
);

  logic [DESC_W-1:0] desc_bus;
  logic [SLOT_W-1:0] rd_slot;
  logic [BYTE_W-1:0] rd_byte;
  logic [7:0]        entry_byte;
  logic [7:0]        body_sum;
  logic [7:0]        sector_byte;

  stl_stream_rx #(.DESC_BYTES(DESC_BYTES)) rx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (wr_valid),
    .in_start (wr_start),
    .in_last  (wr_last),
    .in_data  (wr_data),
    .commit   (desc_accepted),
    .reject   (desc_rejected),
    .desc     (desc_bus)
  );

  stl_log_store #(.ENTRIES(ENTRIES), .DESC_BYTES(DESC_BYTES)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .commit     (desc_accepted),
    .desc       (desc_bus),
    .rd_slot    (rd_slot),
    .rd_byte    (rd_byte),
    .entry_byte (entry_byte),
    .log_ptr    (log_ptr),
    .body_sum   (body_sum)
  );

  stl_sector_map #(
    .ENTRIES(ENTRIES), .DESC_BYTES(DESC_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .REVISION(REVISION)
  ) map_i (
    .rd_addr     (rd_addr),
    .log_ptr     (log_ptr),
    .body_sum    (body_sum),
    .entry_byte  (entry_byte),
    .rd_slot     (rd_slot),
    .rd_byte     (rd_byte),
    .sector_byte (sector_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= sector_byte;
  end

endmodule

// File: rtl/stl_selftest_log_chk.sv
module stl_selftest_log_chk #(
  parameter int unsigned ENTRIES      = 21,
  parameter int unsigned SECTOR_BYTES = 512,
  parameter logic [15:0] REVISION     = 16'h0001,
  localparam int unsigned ADDR_W = $clog2(SECTOR_BYTES),
  localparam int unsigned PTR_W  = $clog2(ENTRIES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              desc_accepted,
  input logic              desc_rejected,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic [PTR_W-1:0]  log_ptr
);

  function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(ENTRIES)) ? PTR_W'(1) : p + PTR_W'(1);
  endfunction

  // R4: pointer never leaves 0..ENTRIES
  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    log_ptr <= PTR_W'(ENTRIES));

  // R4, R5: an accepted descriptor moves the pointer one step round the ring
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_accepted && !clr) |=> (log_ptr == ring_next($past(log_ptr))));

  // R6, R7: only an accept or a clear may move the pointer
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (log_ptr != $past(log_ptr)) |-> ($past(desc_accepted) || $past(clr)));

  // R6: a stream ends in at most one verdict
  p_one_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_accepted && desc_rejected));

  // R13: clear empties the pointer
  p_clear_empty_r13: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (log_ptr == '0));

  // R2, R11: revision low byte one cycle after offset 0
  p_rev_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == '0) |=> (rd_data == REVISION[7:0]));

  // R4, R11: pointer byte mirrors the pointer
  p_ptr_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(SECTOR_BYTES - 4)) |=> (rd_data == 8'($past(log_ptr))));

  // R10: reserved offset reads zero
  p_pad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(SECTOR_BYTES - 2)) |=> (rd_data == 8'h00));

endmodule

bind stl_selftest_log stl_selftest_log_chk #(
  .ENTRIES(ENTRIES), .SECTOR_BYTES(SECTOR_BYTES), .REVISION(REVISION)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr           (clr),
  .desc_accepted (desc_accepted),
  .desc_rejected (desc_rejected),
  .rd_addr       (rd_addr),
  .rd_data       (rd_data),
  .log_ptr       (log_ptr)
);

// File: tb/stl_selftest_log_tb_top.sv
`timescale 1ns/1ps
module stl_selftest_log_tb_top;

  localparam int NE     = 21;
  localparam int DB     = 24;
  localparam int CLK_NS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_start = 1'b0;
  logic       wr_last = 1'b0;
  logic [7:0] wr_data = '0;
  logic       desc_accepted;
  logic       desc_rejected;
  logic [8:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [4:0] log_ptr;

  always #(CLK_NS/2) clk = ~clk;

  stl_selftest_log dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_valid(wr_valid), .wr_start(wr_start), .wr_last(wr_last), .wr_data(wr_data),
    .desc_accepted(desc_accepted), .desc_rejected(desc_rejected),
    .rd_addr(rd_addr), .rd_data(rd_data), .log_ptr(log_ptr)
  );

  int total = 0;
  int bad   = 0;
  logic [7:0] m_ent [NE][DB];
  int m_ptr = 0;

  // len, seed, expect accepted
  localparam int VEC [8][3] = '{
    '{24, 1, 1}, '{24, 2, 1}, '{5, 3, 0}, '{24, 4, 1},
    '{1, 5, 0},  '{30, 6, 0}, '{24, 7, 1}, '{23, 8, 0}
  };

  task automatic chk(input string req, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 37 + i * 11 + 5);
  endfunction

  function automatic void model_clear();
    for (int s = 0; s < NE; s++)
      for (int k = 0; k < DB; k++) m_ent[s][k] = 8'h00;
    m_ptr = 0;
  endfunction

  function automatic int model_commit(input int seed);
    int slot;
    slot = (m_ptr == NE) ? 0 : m_ptr;
    for (int k = 0; k < DB; k++) m_ent[slot][k] = pat(seed, k);
    m_ptr = slot + 1;
    return slot;
  endfunction

  function automatic logic [7:0] exp_byte(input int a);
    logic [7:0] s;
    if (a == 0) return 8'h01;
    if (a == 1) return 8'h00;
    if (a >= 2 && a < 2 + NE*DB) return m_ent[(a-2)/DB][(a-2)%DB];
    if (a == 508) return 8'(m_ptr);
    if (a == 511) begin
      s = 8'h01 + 8'(m_ptr);
      for (int x = 0; x < NE; x++)
        for (int k = 0; k < DB; k++) s = s + m_ent[x][k];
      return 8'(8'd0 - s);
    end
    return 8'h00;
  endfunction

  function automatic string tag_of(input int a);
    if (a < 2) return "R2";
    if (a < 506) return "R3";
    if (a == 508) return "R4";
    if (a == 511) return "R8";
    return "R10";
  endfunction

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk) rd_addr = 9'(a);
    @(negedge clk) v = rd_data;
  endtask

  task automatic send(input int len, input int seed, input bit gap,
                      output bit acc, output bit rej);
    for (int i = 0; i < len; i++) begin
      if (gap && (i % 3 == 1)) begin
        @(negedge clk) wr_valid = 1'b0;
      end
      @(negedge clk);
      wr_valid = 1'b1;
      wr_start = (i == 0);
      wr_last  = (i == len - 1);
      wr_data  = pat(seed, i);
    end
    @(negedge clk);
    acc = desc_accepted;
    rej = desc_rejected;
    wr_valid = 1'b0; wr_start = 1'b0; wr_last = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_slot(input int slot, input string req);
    logic [7:0] v;
    for (int k = 0; k < DB; k++) begin
      rd(2 + slot*DB + k, v);
      chk(req, v, m_ent[slot][k]);
    end
  endtask

  task automatic check_sector();
    logic [7:0] v;
    logic [7:0] sum;
    sum = '0;
    for (int a = 0; a < 512; a++) begin
      rd(a, v);
      sum = sum + v;
      chk(tag_of(a), v, exp_byte(a));
    end
    chk("R8 sector sum", sum, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit acc, rej;
    int slot;
    logic [7:0] v;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 ptr after reset", log_ptr, 0);
    check_sector();

    // R3 R4 R6 R7: vector table
    for (int n = 0; n < 8; n++) begin
      send(VEC[n][0], VEC[n][1], 1'b0, acc, rej);
      if (VEC[n][2] != 0) begin
        chk("R3 accept pulse", acc, 1);
        chk("R3 no reject", rej, 0);
        slot = model_commit(VEC[n][1]);
        chk("R4 ptr", log_ptr, m_ptr);
        check_slot(slot, "R3 contents");
      end else begin
        chk(VEC[n][0] < DB ? "R6 reject pulse" : "R7 reject pulse", rej, 1);
        chk(VEC[n][0] < DB ? "R6 no accept" : "R7 no accept", acc, 0);
        chk(VEC[n][0] < DB ? "R6 ptr kept" : "R7 ptr kept", log_ptr, m_ptr);
      end
    end
    check_sector();

    // R12: gaps inside a stream
    send(DB, 10, 1'b1, acc, rej);
    chk("R12 gapped accept", acc, 1);
    slot = model_commit(10);
    check_slot(slot, "R12 gapped contents");

    // R12: stray beats without an open stream
    @(negedge clk);
    wr_valid = 1'b1; wr_start = 1'b0; wr_last = 1'b1; wr_data = 8'hA5;
    @(negedge clk);
    chk("R12 stray no accept", desc_accepted, 0);
    chk("R12 stray no reject", desc_rejected, 0);
    wr_valid = 1'b0; wr_last = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 stray ptr kept", log_ptr, m_ptr);

    // R9: restart mid-stream
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_start = (i == 0); wr_last = 1'b0; wr_data = 8'hEE;
    end
    send(DB, 11, 1'b0, acc, rej);
    chk("R9 restart accept", acc, 1);
    chk("R9 restart no reject", rej, 0);
    slot = model_commit(11);
    check_slot(slot, "R9 restart contents");

    // R4: fill to the last slot
    for (int k = 0; m_ptr < NE; k++) begin
      send(DB, 20 + k, 1'b0, acc, rej);
      chk("R4 fill accept", acc, 1);
      slot = model_commit(20 + k);
    end
    chk("R4 ptr full", log_ptr, NE);
    check_sector();

    // R5: wrap over the oldest
    send(DB, 50, 1'b0, acc, rej);
    slot = model_commit(50);
    chk("R5 wrap slot", slot, 0);
    chk("R5 wrap ptr", log_ptr, 1);
    send(DB, 51, 1'b0, acc, rej);
    slot = model_commit(51);
    chk("R5 second wrap ptr", log_ptr, 2);
    // R7: overlong stream after a wrap
    send(DB + 1, 52, 1'b0, acc, rej);
    chk("R7 overlong reject", rej, 1);
    chk("R7 ptr kept", log_ptr, 2);
    check_sector();

    // R11: output follows the address one edge later
    @(negedge clk) rd_addr = 9'd508;
    @(negedge clk);
    rd_addr = 9'd0;
    chk("R11 old offset held", rd_data, m_ptr);
    @(negedge clk);
    chk("R11 new offset", rd_data, 8'h01);

    // R13: clear
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    model_clear();
    chk("R13 ptr cleared", log_ptr, 0);
    check_sector();
    send(DB, 60, 1'b0, acc, rej);
    slot = model_commit(60);
    chk("R13 first after clear slot", slot, 0);
    chk("R13 ptr after clear", log_ptr, 1);
    rd(2, v);
    chk("R13 first byte after clear", v, pat(60, 0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule